// File: doc/BRIEF.md
# Cache Flush Snoop Sequencer

This block turns one flush command into a series of snoop requests, one per cache line. A command carries a byte address and a byte length. The block divides the address by the line size to get the first line. It rounds the length up to a whole number of lines. It then offers one request per line on a valid/ready channel. Each request carries a line address and a tag. Both the line address and the tag go up by one for each line that is accepted.

Snoop responses come back on a separate valid/ready channel and carry no payload. The block counts them against the requests it has raised. It keeps its `busy` output high until every line has been sent and every response has been counted. Software or a host sequencer can therefore start a flush and then wait on `busy`. The cache that services the snoops and any coherence action it takes are outside this block.

Back-pressure rules:
- The request channel holds its line address and tag stable while `snp_req_ready` is low.
- The command channel accepts a command only when `cmd_ready` is high, which happens only while the block is idle.
- The response channel is ready for the whole active period and never while idle.

Top module: `flush_snoop_seq`

## Requirements
- R1: After a command with a nonzero length is accepted, the first request appears in the next cycle. It carries line address `cmd_addr >> log2(LINE_BYTES)` (modulo 2^LADDR_W) and tag 0.
- R2: The number of requests accepted for one command equals `ceil(cmd_size / LINE_BYTES)`.
- R3: A command with `cmd_size` equal to 0 is consumed (`cmd_ready` high) but ignored. No request is raised, and `busy` stays low.
- R4: The request advances only in a cycle where `snp_req_valid` and `snp_req_ready` are both high. The next request then carries line address + 1 and tag + 1, and the tag wraps modulo 2^TAG_W. While the request is stalled, its line address and tag hold stable.
- R5: `snp_req_valid` stays high from the first request until the last line is accepted, and it is low from the cycle after that acceptance.
- R6: `busy` stays high while any request is unsent or any raised request is unanswered. After the final response is presented, `busy` is still high in the next cycle and low in the cycle after that.
- R7: `snp_rsp_ready` is high exactly while `busy` is high. `snp_req_valid` is low whenever `busy` is low.
- R8: `cmd_ready` is low while `busy` is high. A command presented during that time has no effect on the running sequence.
- R9: A response that arrives while the outstanding count is zero is a protocol error.
- R10: Responses that arrive before all lines have been sent do not end the active period early. The outstanding count is set to 1 when the first request is raised, rises by one for each further request launched, and falls by one for each response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Flush command present |
| cmd_ready | output | 1 | Command accepted; high only when idle |
| cmd_addr | input | ADDR_W | Byte address where the flush starts |
| cmd_size | input | SIZE_W | Byte length of the flush range |
| busy | output | 1 | High while a flush is active |
| snp_req_valid | output | 1 | Snoop request present |
| snp_req_ready | input | 1 | Snoop request accepted |
| snp_req_line | output | ADDR_W-log2(LINE_BYTES) | Line address of the request |
| snp_req_tag | output | TAG_W | Tag of the request |
| snp_rsp_valid | input | 1 | Snoop response present |
| snp_rsp_ready | output | 1 | Response accepted; high while active |

## Verification
The assertions assume the responder never answers more requests than it has accepted. Without that, the outstanding count would underflow, which is exactly what the error check flags. The bench model meets this assumption by raising `snp_rsp_valid` only while the number of accepted requests exceeds the number of responses already given. The checks also assume that a command presented while busy is simply held off. The bench drives junk commands during active periods and checks that the line and tag sequence is undisturbed. It stops presenting commands once the final response has been given, so that no command is accepted the moment the block goes idle.

// File: rtl/fss_pkg.sv
package fss_pkg;
  typedef enum logic {
    FS_IDLE   = 1'b0,
    FS_ACTIVE = 1'b1
  } fs_state_t;
endpackage

// File: rtl/fss_line_walker.sv
// Holds the current line address, tag and remaining line count.
// Raises the request and steps on each accepted request.
module fss_line_walker #(
  parameter int LADDR_W = 26,
  parameter int TAG_W   = 8,
  parameter int CNT_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LADDR_W-1:0] load_line,
  input  logic [CNT_W-1:0]   load_count,
  input  logic               step,
  output logic               req_valid,
  output logic [LADDR_W-1:0] line,
  output logic [TAG_W-1:0]   tag,
  output logic               last
);
  logic [CNT_W-1:0] remaining;

  assign last = (remaining == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      line      <= '0;
      tag       <= '0;
      remaining <= '0;
    end else if (load) begin
      req_valid <= 1'b1;
      line      <= load_line;
      tag       <= '0;
      remaining <= load_count;
    end else if (step) begin
      if (last) begin
        req_valid <= 1'b0;
      end else begin
        line <= line + LADDR_W'(1);
        tag  <= tag + TAG_W'(1);
      end
      remaining <= remaining - CNT_W'(1);
    end
  end
endmodule

// File: rtl/fss_pending_ctr.sv
// Counts requests raised but not yet answered.
module fss_pending_ctr #(
  parameter int PEND_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              inc,
  input  logic              dec,
  output logic [PEND_W-1:0] count,
  output logic              empty
);
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (start) begin
      count <= PEND_W'(1);
    end else if (inc && !dec) begin
      count <= count + PEND_W'(1);
    end else if (dec && !inc) begin
      count <= count - PEND_W'(1);
    end
  end
endmodule

// File: rtl/flush_snoop_seq.sv
module flush_snoop_seq #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 16,
  parameter int LINE_BYTES = 64,
  parameter int TAG_W      = 8,
  localparam int LSB       = $clog2(LINE_BYTES),
  localparam int LADDR_W   = ADDR_W - LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [SIZE_W-1:0]  cmd_size,
  output logic               busy,
  output logic               snp_req_valid,
  input  logic               snp_req_ready,
  output logic [LADDR_W-1:0] snp_req_line,
  output logic [TAG_W-1:0]   snp_req_tag,
  input  logic               snp_rsp_valid,
  output logic               snp_rsp_ready
);
  import fss_pkg::*;

  localparam int CNT_W = SIZE_W - LSB + 1;

  fs_state_t        state_q;
  logic             start;
  logic             fire;
  logic             last;
  logic             rsp_take;
  logic             pend_empty;
  logic [CNT_W-1:0] pend_cnt;
  logic [SIZE_W:0]  size_round;
  logic [CNT_W-1:0] line_count;

  // Round the byte length up to whole lines.
  assign size_round = {1'b0, cmd_size} + (SIZE_W+1)'(LINE_BYTES - 1);
  assign line_count = CNT_W'(size_round >> LSB);

  assign cmd_ready     = (state_q == FS_IDLE);
  assign busy          = (state_q == FS_ACTIVE);
  assign snp_rsp_ready = busy;
  assign start         = cmd_valid && cmd_ready && (cmd_size != '0);
  assign fire          = snp_req_valid && snp_req_ready;
  assign rsp_take      = snp_rsp_valid && snp_rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
    end else begin
      case (state_q)
        FS_IDLE:   if (start) state_q <= FS_ACTIVE;
        FS_ACTIVE: if (!snp_req_valid && pend_empty) state_q <= FS_IDLE;
        default:   state_q <= FS_IDLE;
      endcase
    end
  end

  fss_line_walker #(
    .LADDR_W (LADDR_W),
    .TAG_W   (TAG_W),
    .CNT_W   (CNT_W)
  ) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .load_line  (cmd_addr[ADDR_W-1:LSB]),
    .load_count (line_count),
    .step       (fire),
    .req_valid  (snp_req_valid),
    .line       (snp_req_line),
    .tag        (snp_req_tag),
    .last       (last)
  );

  fss_pending_ctr #(
    .PEND_W (CNT_W)
  ) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .inc   (fire && !last),
    .dec   (rsp_take),
    .count (pend_cnt),
    .empty (pend_empty)
  );
endmodule

// File: rtl/fss_chk.sv
module fss_chk #(
  parameter int LADDR_W = 26,
  parameter int TAG_W   = 8,
  parameter int PEND_W  = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_ready,
  input logic               busy,
  input logic               snp_req_valid,
  input logic               snp_req_ready,
  input logic [LADDR_W-1:0] snp_req_line,
  input logic [TAG_W-1:0]   snp_req_tag,
  input logic               snp_rsp_valid,
  input logic               snp_rsp_ready,
  input logic [PEND_W-1:0]  pend_cnt
);
  // R1
  first_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> snp_req_valid && (snp_req_tag == '0) && (pend_cnt == PEND_W'(1)));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_req_valid && !snp_req_ready |=> snp_req_valid && $stable(snp_req_line) && $stable(snp_req_tag));

  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(snp_req_valid && snp_req_ready) && snp_req_valid |->
      (snp_req_line == $past(snp_req_line) + LADDR_W'(1)) && (snp_req_tag == $past(snp_req_tag) + TAG_W'(1)));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !snp_req_valid && !snp_rsp_ready);

  // R8
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_rsp_valid && snp_rsp_ready |-> pend_cnt != '0);

  // R6
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (snp_req_valid || pend_cnt != '0) |=> busy);
endmodule

bind flush_snoop_seq fss_chk #(
  .LADDR_W (LADDR_W),
  .TAG_W   (TAG_W),
  .PEND_W  (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ready     (cmd_ready),
  .busy          (busy),
  .snp_req_valid (snp_req_valid),
  .snp_req_ready (snp_req_ready),
  .snp_req_line  (snp_req_line),
  .snp_req_tag   (snp_req_tag),
  .snp_rsp_valid (snp_rsp_valid),
  .snp_rsp_ready (snp_rsp_ready),
  .pend_cnt      (pend_cnt)
);

// File: tb/flush_snoop_seq_tb.sv
module flush_snoop_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int SIZE_W     = 6;
  localparam int LINE_BYTES = 4;
  localparam int TAG_W      = 3;
  localparam int LADDR_W    = ADDR_W - 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cmd_valid = 1'b0;
  logic               cmd_ready;
  logic [ADDR_W-1:0]  cmd_addr = '0;
  logic [SIZE_W-1:0]  cmd_size = '0;
  logic               busy;
  logic               snp_req_valid;
  logic               snp_req_ready = 1'b0;
  logic [LADDR_W-1:0] snp_req_line;
  logic [TAG_W-1:0]   snp_req_tag;
  logic               snp_rsp_valid = 1'b0;
  logic               snp_rsp_ready;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flush_snoop_seq #(
    .ADDR_W     (ADDR_W),
    .SIZE_W     (SIZE_W),
    .LINE_BYTES (LINE_BYTES),
    .TAG_W      (TAG_W)
  ) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_addr      (cmd_addr),
    .cmd_size      (cmd_size),
    .busy          (busy),
    .snp_req_valid (snp_req_valid),
    .snp_req_ready (snp_req_ready),
    .snp_req_line  (snp_req_line),
    .snp_req_tag   (snp_req_tag),
    .snp_rsp_valid (snp_rsp_valid),
    .snp_rsp_ready (snp_rsp_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_flush(input int addr, input int size);
    int exp_lines = (size + LINE_BYTES - 1) / LINE_BYTES;
    int base = addr / LINE_BYTES;
    int fires = 0;
    int resp = 0;
    int done_cyc = -1;
    int seed = addr + size;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_addr  = ADDR_W'(addr);
    cmd_size  = SIZE_W'(size);
    #1;
    check(cmd_ready == 1'b1, "R8 idle cmd_ready", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (exp_lines == 0) begin
      for (int k = 0; k < 3; k++) begin
        #1;
        check(!busy && !snp_req_valid, "R3 zero size", int'(busy), 0);
        @(negedge clk);
      end
      return;
    end
    for (int cyc = 0; cyc < 2000; cyc++) begin
      snp_req_ready = ((cyc + seed) % 3) != 0;
      snp_rsp_valid = (fires > resp) && (((cyc + seed) % 2) == 0);
      cmd_valid = (done_cyc < 0) && ((cyc % 5) == 1);
      cmd_addr  = ADDR_W'(cyc * 37 + 11);
      cmd_size  = SIZE_W'(cyc + 3);
      #1;
      check(snp_rsp_ready == busy, "R7 rsp_ready", int'(snp_rsp_ready), int'(busy));
      check(cmd_ready == !busy, "R8 cmd_ready", int'(cmd_ready), int'(!busy));
      if (done_cyc >= 0 && cyc == done_cyc + 2) begin
        check(busy == 1'b0, "R6 busy drop", int'(busy), 0);
        check(snp_req_valid == 1'b0, "R7 idle valid", int'(snp_req_valid), 0);
        snp_rsp_valid = 1'b0;
        break;
      end
      check(busy == 1'b1, "R6 R10 busy held", int'(busy), 1);
      check(snp_req_valid == (fires < exp_lines), "R5 valid", int'(snp_req_valid), int'(fires < exp_lines));
      if (snp_req_valid) begin
        if (fires == 0) begin
          check(int'(snp_req_line) == base % 64, "R1 first line", int'(snp_req_line), base % 64);
          check(snp_req_tag == 0, "R1 first tag", int'(snp_req_tag), 0);
        end else begin
          check(int'(snp_req_line) == (base + fires) % 64, "R4 line", int'(snp_req_line), (base + fires) % 64);
          check(int'(snp_req_tag) == fires % 8, "R4 tag", int'(snp_req_tag), fires % 8);
        end
        if (snp_req_ready) fires++;
      end
      if (snp_rsp_valid) begin
        resp++;
        if (resp == exp_lines) done_cyc = cyc;
      end
      @(negedge clk);
      if (cyc == 1999) check(1'b0, "R6 run timeout", cyc, 0);
    end
    check(fires == exp_lines, "R2 line count", fires, exp_lines);
    cmd_valid = 1'b0;
    snp_req_ready = 1'b0;
    snp_rsp_valid = 1'b0;
  endtask

  initial begin
    int addrs[7] = '{0, 3, 4, 5, 127, 250, 255};
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !snp_req_valid && !snp_rsp_ready, "R7 reset state", int'(busy), 0);
    check(cmd_ready == 1'b0 || cmd_ready == 1'b1, "R8 reset cmd_ready known", int'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(cmd_ready == 1'b1, "R8 idle after reset", int'(cmd_ready), 1);
    for (int a = 0; a < 7; a++) begin
      for (int s = 0; s <= 40; s++) begin
        run_flush(addrs[a], s);
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule